// File: doc/BRIEF.md
# Age-Ordered Crossbar Slice

This block joins a set of source ports to a set of destination ports. Every source offers one transaction per cycle with a destination code, a payload and a valid/ready handshake. Each (source, destination) pair has a private shallow queue. One source is blocked only when the queue toward the destination it currently names is full, so a stalled destination does not block traffic from that source to other destinations.

Each destination has its own arbiter. It looks only at the head of every queue aimed at it and grants the head that has waited longest. Ages count cycles since acceptance and saturate at 63. When ages are equal, the lower source index wins. The winner is copied into a registered output stage that holds while the consumer stalls. The order in which transactions leave a destination is therefore fixed by acceptance time, so the slice is the single ordering point for everything that passes through it.

One extra port, the highest-numbered source and destination, is set aside for an I/O subsystem. It behaves like every other port.

Top module: `xbar_age_slice`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, every dst_valid bit is 0. Every source that names a legal destination sees src_ready = 1. Reset discards every queued transaction, so none of them is delivered afterwards.
- R2: Each source/destination pair queue holds QDEPTH entries (default 2). When the pair named by a source is full, src_ready is 0 for that source, and a transaction held valid is not accepted.
- R3: A destination code equal to or above the number of destinations (code 3 with the defaults) gives src_ready = 0, and the transaction is never accepted or delivered.
- R4: Transactions from one source to one destination leave in the order they were accepted.
- R5: A destination delivers the queue head that was accepted earliest, whatever its source index, as long as ages are below saturation.
- R6: Heads with equal age are granted lowest source index first.
- R7: A destination loads at most one transaction per cycle. Different destinations may take the heads of one source's queues on the same clock edge.
- R8: While dst_valid is 1 and dst_ready is 0, dst_valid, dst_data and dst_src stay unchanged.
- R9: Suppose a transaction is accepted on edge k into an empty path, and its destination output is empty or being consumed. Then it appears on dst_valid/dst_data after edge k+1, with dst_src giving the source index in binary.
- R10: Source index NUM_CORE_SRC and destination index NUM_CORE_DST form the I/O port, and they obey the same rules as the core ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NS | Per-source transaction valid |
| src_dst | input | NS*DST_W | Per-source destination code |
| src_data | input | NS*DATA_W | Per-source payload |
| src_ready | output | NS | Per-source accept |
| dst_valid | output | ND | Per-destination output valid |
| dst_data | output | ND*DATA_W | Per-destination payload |
| dst_src | output | ND*SRC_W | Source index of the delivered transaction |
| dst_ready | input | ND | Per-destination consumer ready |

## Verification
The checker places no restriction on dst_ready or on src_dst. It does assume that reset is applied before the first checked cycle, because it rebuilds each pair's occupancy from the handshakes and the outputs that are loaded, starting from empty. The stimulus asserts reset at time zero and changes inputs only shortly after a rising edge. It keeps every stall well under 63 cycles, so the age order that the bench predicts is never blurred by saturation.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int AGE_W = 6;
  typedef logic [AGE_W-1:0] age_t;
  localparam age_t AGE_MAX = '1;
endpackage

// File: rtl/xbar_pair_q.sv
module xbar_pair_q
  import xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  output age_t              head_age
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  age_t              age [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic              do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt == CW'(DEPTH));
  assign head_valid = (cnt != '0);
  assign do_push    = push && !full;
  assign do_pop     = pop && head_valid;
  assign head_data  = mem[rd_ptr];
  assign head_age   = age[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // each slot restarts its wait counter on write and saturates
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                                   age[i] <= '0;
      else if (do_push && wr_ptr == PW'(i))      age[i] <= '0;
      else if (age[i] != AGE_MAX)                age[i] <= age[i] + 1'b1;
    end
  end
endmodule

// File: rtl/xbar_age_arb.sv
module xbar_age_arb
  import xbar_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NREQ-1:0]  req,
  input  age_t             age_in [NREQ],
  output logic [NREQ-1:0]  gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_any
);
  age_t best_age;

  // ascending scan with strict compare: equal ages keep the lower index
  always_comb begin
    gnt_any  = 1'b0;
    gnt_idx  = '0;
    best_age = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i] && (!gnt_any || age_in[i] > best_age)) begin
        gnt_any  = 1'b1;
        gnt_idx  = IDX_W'(i);
        best_age = age_in[i];
      end
    end
    gnt = '0;
    if (gnt_any) gnt[gnt_idx] = 1'b1;
  end
endmodule

// File: rtl/xbar_out_reg.sv
module xbar_out_reg #(
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SRC_W-1:0]  in_src,
  input  logic              out_ready,
  output logic              free,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [SRC_W-1:0]  out_src
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)       out_valid <= 1'b0;
    else if (free) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (free && in_valid) begin
      out_data <= in_data;
      out_src  <= in_src;
    end
  end
endmodule

// File: rtl/xbar_age_slice.sv
module xbar_age_slice
  import xbar_pkg::*;
#(
  parameter int NUM_CORE_SRC = 3,
  parameter int NUM_CORE_DST = 2,
  parameter int DATA_W       = 8,
  parameter int QDEPTH       = 2,
  localparam int NS    = NUM_CORE_SRC + 1,
  localparam int ND    = NUM_CORE_DST + 1,
  localparam int SRC_W = (NS > 1) ? $clog2(NS) : 1,
  localparam int DST_W = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NS-1:0]        src_valid,
  input  logic [NS*DST_W-1:0]  src_dst,
  input  logic [NS*DATA_W-1:0] src_data,
  output logic [NS-1:0]        src_ready,
  output logic [ND-1:0]        dst_valid,
  output logic [ND*DATA_W-1:0] dst_data,
  output logic [ND*SRC_W-1:0]  dst_src,
  input  logic [ND-1:0]        dst_ready
);
  logic [DST_W-1:0]  sel_dst [NS];
  logic [NS-1:0]     dst_ok;

  logic              q_push  [NS][ND];
  logic              q_pop   [NS][ND];
  logic              q_full  [NS][ND];
  logic              q_hval  [NS][ND];
  logic [DATA_W-1:0] q_hdata [NS][ND];
  age_t              q_hage  [NS][ND];

  logic [NS-1:0]     arb_req [ND];
  age_t              arb_age [ND][NS];
  logic [NS-1:0]     arb_gnt [ND];
  logic [SRC_W-1:0]  arb_idx [ND];
  logic [ND-1:0]     arb_any;
  logic [ND-1:0]     out_free;
  logic [DATA_W-1:0] win_data [ND];

  // source side: decode destination code and build ready
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      sel_dst[s]   = src_dst[s*DST_W +: DST_W];
      dst_ok[s]    = (sel_dst[s] <= DST_W'(ND - 1));
      src_ready[s] = 1'b0;
      for (int d = 0; d < ND; d++) begin
        if (dst_ok[s] && sel_dst[s] == DST_W'(d)) src_ready[s] = !q_full[s][d];
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    for (genvar d = 0; d < ND; d++) begin : g_pair
      assign q_push[s][d] = src_valid[s] && dst_ok[s] &&
                            (sel_dst[s] == DST_W'(d)) && !q_full[s][d];
      assign q_pop[s][d]  = arb_gnt[d][s] && out_free[d];

      xbar_pair_q #(.DATA_W(DATA_W), .DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push[s][d]),
        .push_data (src_data[s*DATA_W +: DATA_W]),
        .pop       (q_pop[s][d]),
        .full      (q_full[s][d]),
        .head_valid(q_hval[s][d]),
        .head_data (q_hdata[s][d]),
        .head_age  (q_hage[s][d])
      );
    end
  end

  // destination side: gather heads, arbitrate by age, register the winner
  always_comb begin
    for (int d = 0; d < ND; d++) begin
      win_data[d] = '0;
      for (int s = 0; s < NS; s++) begin
        arb_req[d][s] = q_hval[s][d];
        arb_age[d][s] = q_hage[s][d];
        if (arb_idx[d] == SRC_W'(s)) win_data[d] = q_hdata[s][d];
      end
    end
  end

  for (genvar d = 0; d < ND; d++) begin : g_dst
    xbar_age_arb #(.NREQ(NS), .IDX_W(SRC_W)) u_arb (
      .req    (arb_req[d]),
      .age_in (arb_age[d]),
      .gnt    (arb_gnt[d]),
      .gnt_idx(arb_idx[d]),
      .gnt_any(arb_any[d])
    );

    xbar_out_reg #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .in_valid (arb_any[d]),
      .in_data  (win_data[d]),
      .in_src   (arb_idx[d]),
      .out_ready(dst_ready[d]),
      .free     (out_free[d]),
      .out_valid(dst_valid[d]),
      .out_data (dst_data[d*DATA_W +: DATA_W]),
      .out_src  (dst_src[d*SRC_W +: SRC_W])
    );
  end
endmodule

// File: rtl/xbar_age_slice_chk.sv
module xbar_age_slice_chk #(
  parameter int NUM_CORE_SRC = 3,
  parameter int NUM_CORE_DST = 2,
  parameter int DATA_W       = 8,
  parameter int QDEPTH       = 2,
  localparam int NS    = NUM_CORE_SRC + 1,
  localparam int ND    = NUM_CORE_DST + 1,
  localparam int SRC_W = (NS > 1) ? $clog2(NS) : 1,
  localparam int DST_W = (ND > 1) ? $clog2(ND) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NS-1:0]        src_valid,
  input logic [NS*DST_W-1:0]  src_dst,
  input logic [NS*DATA_W-1:0] src_data,
  input logic [NS-1:0]        src_ready,
  input logic [ND-1:0]        dst_valid,
  input logic [ND*DATA_W-1:0] dst_data,
  input logic [ND*SRC_W-1:0]  dst_src,
  input logic [ND-1:0]        dst_ready
);
  logic [7:0]  occ     [NS][ND];
  logic [7:0]  occ_now [NS][ND];
  logic        pushed  [NS][ND];
  logic        loaded  [NS][ND];
  logic [ND-1:0] free_q;

  // pair occupancy rebuilt from port handshakes and observed output loads
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int d = 0; d < ND; d++) begin
        pushed[s][d]  = src_valid[s] && src_ready[s] &&
                        (src_dst[s*DST_W +: DST_W] == DST_W'(d));
        loaded[s][d]  = free_q[d] && dst_valid[d] &&
                        (dst_src[d*SRC_W +: SRC_W] == SRC_W'(s));
        occ_now[s][d] = occ[s][d] - {7'd0, loaded[s][d]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
      for (int s = 0; s < NS; s++)
        for (int d = 0; d < ND; d++) occ[s][d] <= '0;
    end else begin
      free_q <= ~dst_valid | dst_ready;
      for (int s = 0; s < NS; s++)
        for (int d = 0; d < ND; d++)
          occ[s][d] <= occ_now[s][d] + {7'd0, pushed[s][d]};
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dst_valid == '0)
    else $error("R1: output valid right after reset");

  for (genvar s = 0; s < NS; s++) begin : g_s
    a_r3_bad_code_blocked: assert property (@(posedge clk) disable iff (rst)
      (src_dst[s*DST_W +: DST_W] > DST_W'(ND - 1)) |-> !src_ready[s])
      else $error("R3: illegal destination code accepted");

    for (genvar d = 0; d < ND; d++) begin : g_d
      a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ_now[s][d] <= 8'(QDEPTH))
        else $error("R2: pair queue beyond depth");

      a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (occ_now[s][d] == 8'(QDEPTH) && src_dst[s*DST_W +: DST_W] == DST_W'(d))
          |-> !src_ready[s])
        else $error("R2: ready while pair queue full");
    end
  end

  for (genvar d = 0; d < ND; d++) begin : g_o
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (dst_valid[d] && !dst_ready[d]) |=>
        (dst_valid[d] && $stable(dst_data[d*DATA_W +: DATA_W]) &&
         $stable(dst_src[d*SRC_W +: SRC_W])))
      else $error("R8: stalled output changed");
  end
endmodule

bind xbar_age_slice xbar_age_slice_chk #(
  .NUM_CORE_SRC(NUM_CORE_SRC),
  .NUM_CORE_DST(NUM_CORE_DST),
  .DATA_W      (DATA_W),
  .QDEPTH      (QDEPTH)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .src_valid(src_valid),
  .src_dst  (src_dst),
  .src_data (src_data),
  .src_ready(src_ready),
  .dst_valid(dst_valid),
  .dst_data (dst_data),
  .dst_src  (dst_src),
  .dst_ready(dst_ready)
);

// File: tb/test_xbar_age_slice.sv
`timescale 1ns/1ps
module test_xbar_age_slice;
  localparam int NS = 4, ND = 3, DW = 8, SW = 2, DSW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NS-1:0]     src_valid = '0;
  logic [NS*DSW-1:0] src_dst   = '0;
  logic [NS*DW-1:0]  src_data  = '0;
  logic [NS-1:0]     src_ready;
  logic [ND-1:0]     dst_valid;
  logic [ND*DW-1:0]  dst_data;
  logic [ND*SW-1:0]  dst_src;
  logic [ND-1:0]     dst_ready = '1;

  int checks = 0;
  int fails  = 0;

  xbar_age_slice #(.NUM_CORE_SRC(3), .NUM_CORE_DST(2), .DATA_W(DW), .QDEPTH(2)) i_xbar_age_slice (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_dst(src_dst), .src_data(src_data),
    .src_ready(src_ready), .dst_valid(dst_valid), .dst_data(dst_data), .dst_src(dst_src),
    .dst_ready(dst_ready)
  );

  // table: inputs for one edge, outputs expected after that edge ({d2,d1,d0})
  localparam int NROW = 7;
  localparam logic [3:0]  T_VALID [NROW] = '{4'b1111, 4'b0000, 4'b0000, 4'b0110, 4'b0000, 4'b0000, 4'b0000};
  localparam logic [7:0]  T_DST   [NROW] = '{8'b10_01_00_00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [31:0] T_DATA  [NROW] = '{32'h40302010, 32'h0, 32'h0, 32'h00312100, 32'h0, 32'h0, 32'h0};
  localparam logic [2:0]  T_EV    [NROW] = '{3'b000, 3'b111, 3'b001, 3'b000, 3'b001, 3'b001, 3'b000};
  localparam logic [23:0] T_ED    [NROW] = '{24'h0, 24'h403010, 24'h000020, 24'h0, 24'h000021, 24'h000031, 24'h0};
  localparam logic [5:0]  T_ES    [NROW] = '{6'b0, 6'b11_10_00, 6'b00_00_01, 6'b0, 6'b00_00_01, 6'b00_00_10, 6'b0};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    src_valid = '0;
    src_dst   = '0;
    src_data  = '0;
  endtask

  task automatic put(input int s, input int d, input logic [7:0] v);
    src_valid[s]           = 1'b1;
    src_dst[s*DSW +: DSW]  = DSW'(d);
    src_data[s*DW +: DW]   = v;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_dst(input string tag, input int d, input logic v,
                         input logic [7:0] data, input logic [1:0] src);
    chk({tag, " valid"}, 32'(dst_valid[d]), 32'(v));
    if (v) begin
      chk({tag, " data"}, 32'(dst_data[d*DW +: DW]), 32'(data));
      chk({tag, " src"},  32'(dst_src[d*SW +: SW]),  32'(src));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: all requirements, actual hung run expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) tick();
    // R1: outputs idle and ready high during reset
    chk("R1 reset dst_valid", 32'(dst_valid), 32'h0);
    chk("R1 reset src_ready", 32'(src_ready), 32'hF);
    rst = 1'b0;
    tick();
    chk("R1 after release dst_valid", 32'(dst_valid), 32'h0);

    // table walk: R9 latency, R6 ties, R10 I/O source to I/O destination
    for (int r = 0; r < NROW; r++) begin
      src_valid = T_VALID[r];
      src_dst   = T_DST[r];
      src_data  = T_DATA[r];
      tick();
      idle();
      for (int d = 0; d < ND; d++)
        chk_dst($sformatf("R6 R9 R10 row %0d dst %0d", r, d), d, T_EV[r][d],
                T_ED[r][d*8 +: 8], T_ES[r][d*2 +: 2]);
    end

    // R5/R4/R2/R8: stall destination 0 and build up an age order
    dst_ready = 3'b110;
    put(1, 0, 8'h51); tick(); idle();
    tick();
    chk_dst("R9 stalled load", 0, 1'b1, 8'h51, 2'd1);
    put(2, 0, 8'h62); tick(); idle();
    chk_dst("R8 hold under stall", 0, 1'b1, 8'h51, 2'd1);
    put(0, 0, 8'h70); tick(); idle();
    put(0, 0, 8'h71); tick(); idle();
    put(0, 0, 8'h72); #1;
    chk("R2 full pair ready low", 32'(src_ready[0]), 32'h0);
    chk("R2 other pair ready high", 32'(src_ready[1]), 32'h1);
    tick();
    chk_dst("R8 hold after refused push", 0, 1'b1, 8'h51, 2'd1);
    idle();
    dst_ready = 3'b111;
    tick();
    chk_dst("R5 older higher index first", 0, 1'b1, 8'h62, 2'd2);
    tick();
    chk_dst("R4 pair order first", 0, 1'b1, 8'h70, 2'd0);
    tick();
    chk_dst("R4 pair order second", 0, 1'b1, 8'h71, 2'd0);
    tick();
    chk_dst("R2 refused push never delivered", 0, 1'b0, 8'h0, 2'd0);

    // R3: illegal destination code 3
    put(1, 3, 8'h99); #1;
    chk("R3 illegal code ready low", 32'(src_ready[1]), 32'h0);
    tick(); idle(); tick(); tick();
    chk("R3 nothing delivered", 32'(dst_valid), 32'h0);

    // R7/R10: one source feeds two destinations on the same edge
    dst_ready = 3'b000;
    put(3, 0, 8'hA0); put(2, 1, 8'hA1); tick(); idle();
    tick();
    chk_dst("R10 I/O source to core dst", 0, 1'b1, 8'hA0, 2'd3);
    put(0, 0, 8'hB0); tick(); idle();
    put(0, 1, 8'hB1); tick(); idle();
    dst_ready = 3'b011;
    tick();
    chk_dst("R7 dst0 from src0 same edge", 0, 1'b1, 8'hB0, 2'd0);
    chk_dst("R7 dst1 from src0 same edge", 1, 1'b1, 8'hB1, 2'd0);
    tick();
    chk("R7 one per destination", 32'(dst_valid), 32'h0);

    // R1: reset mid-run drops queued work
    dst_ready = 3'b000;
    put(1, 2, 8'hEE); put(2, 2, 8'hEF); tick(); idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    dst_ready = 3'b111;
    tick(); tick(); tick();
    chk("R1 reset flushes queues", 32'(dst_valid), 32'h0);
    chk("R1 ready after flush", 32'(src_ready), 32'hF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule